// File: doc/BRIEF.md
# ADC Result Register Pair with Read Interlock

This block holds the most recent result of a 10-bit successive-approximation converter and presents it to a CPU as two byte-wide read registers, a high byte and a low byte. Each time the converter raises its completion strobe, the block captures the 10-bit result. The CPU then reads the two bytes through separate read strobes.

Two result formats exist. In ten-bit format, the high register carries the top two result bits and the low register carries the bottom eight. In eight-bit format, only the low register carries data, and it holds the eight most significant result bits.

In ten-bit format, a high-byte read freezes the pair until the low byte is read. This guarantees that a high/low read sequence returns bytes from the same conversion. A conversion that finishes while the pair is frozen is thrown away. Eight-bit format has no freeze.

Top module: `adc_result_hold`

## Requirements
- R1: With `wide_mode_i`=1 (ten-bit format), `hi_data_o` shows stored result bits 9:8 in its bits 1:0, and its bits 7:2 read 0.
- R2: With `wide_mode_i`=0 (eight-bit format), `hi_data_o` reads 0x00.
- R3: A capture in ten-bit format puts result bits 7:0 into the low register. A capture in eight-bit format puts result bits 9:2 into it. `lo_data_o` shows the low register.
- R4: After reset, both outputs read 0x00 and no freeze is active.
- R5: A `conv_done_i` pulse with no freeze active captures `conv_data_i`, and the outputs show it from the next cycle.
- R6: In ten-bit format, a `rd_hi_i` pulse sets the freeze. A `rd_lo_i` pulse clears it. If both arrive in the same cycle, the freeze ends up clear.
- R7: A conversion that completes while the freeze is active, with no `rd_lo_i` in the same cycle, leaves both registers unchanged. It is not applied later.
- R8: In eight-bit format, `rd_hi_i` never sets the freeze, and every completed conversion is captured.
- R9: A `rd_lo_i` pulse while no freeze is active changes neither output nor the capture of the next conversion.
- R10: A `conv_done_i` pulse in the same cycle as the `rd_lo_i` that clears the freeze is captured.
- R11: One cycle with `wide_mode_i`=0 clears any pending freeze. A later conversion in ten-bit format is therefore captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | Conversion-complete strobe |
| conv_data_i | input | 10 | Converter result |
| wide_mode_i | input | 1 | 1 = ten-bit format, 0 = eight-bit format |
| rd_hi_i | input | 1 | High-register read strobe |
| rd_lo_i | input | 1 | Low-register read strobe |
| hi_data_o | output | 8 | High-register read data |
| lo_data_o | output | 8 | Low-register read data |

## Verification
The hardest states to reach are those where several events coincide at a freeze edge. These include a completion in the same cycle as the clearing low read, a high and low read together, and a format change while a freeze is pending. Random strobes rarely line these up. Directed sequences therefore build each of them on purpose: freeze, then collide, then observe. A long random phase follows, with read strobes weighted heavily so that freezes form and break often, checked every cycle against a bench model.

// File: rtl/adc_rh_pkg.sv
package adc_rh_pkg;
  localparam int unsigned RES_W  = 10;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic {MODE_NARROW = 1'b0, MODE_WIDE = 1'b1} rh_mode_e;
endpackage

// File: rtl/adc_rh_lock.sv
module adc_rh_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wide_i,
  input  logic rd_hi_i,
  input  logic rd_lo_i,
  output logic lock_o,
  output logic accept_o
);
  logic lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (!wide_i)      lock_d = 1'b0;
    else if (rd_lo_i) lock_d = 1'b0;
    else if (rd_hi_i) lock_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_d;
  end

  assign lock_o   = lock_q;
  assign accept_o = !wide_i || !lock_q || rd_lo_i;

  // R6
  hi_read_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && rd_hi_i && !rd_lo_i) |=> lock_q);
  // R6
  lo_read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> !lock_q);
  // R11
  narrow_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |=> !lock_q);
endmodule

// File: rtl/adc_rh_store.sv
module adc_rh_store #(
  parameter int unsigned RES_W  = adc_rh_pkg::RES_W,
  parameter int unsigned BYTE_W = adc_rh_pkg::BYTE_W,
  localparam int unsigned HI_W  = RES_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [RES_W-1:0]  data_i,
  output logic [HI_W-1:0]   hi_q_o,
  output logic [BYTE_W-1:0] lo_q_o
);
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [BYTE_W-1:0] lo_q, lo_d;

  always_comb begin
    if (wide_i) begin
      hi_d = data_i[RES_W-1 -: HI_W];
      lo_d = data_i[BYTE_W-1:0];
    end else begin
      hi_d = '0;
      lo_d = data_i[RES_W-1 -: BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_q_o = hi_q;
  assign lo_q_o = lo_q;

  // R3
  wide_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && wide_i) |=> (lo_q == $past(data_i[BYTE_W-1:0])));
  // R3
  narrow_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wide_i) |=> (lo_q == $past(data_i[RES_W-1 -: BYTE_W])));
  // R7
  no_load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/adc_rh_view.sv
module adc_rh_view #(
  parameter int unsigned RES_W  = adc_rh_pkg::RES_W,
  parameter int unsigned BYTE_W = adc_rh_pkg::BYTE_W,
  localparam int unsigned HI_W  = RES_W - BYTE_W
) (
  input  logic              wide_i,
  input  logic [HI_W-1:0]   hi_q_i,
  input  logic [BYTE_W-1:0] lo_q_i,
  output logic [BYTE_W-1:0] hi_data_o,
  output logic [BYTE_W-1:0] lo_data_o
);
  logic [BYTE_W-1:0] hi_ext;

  generate
    if (HI_W < BYTE_W) begin : g_pad
      assign hi_ext = {{(BYTE_W-HI_W){1'b0}}, hi_q_i};
    end else begin : g_trunc
      assign hi_ext = hi_q_i[BYTE_W-1:0];
    end
  endgenerate

  always_comb begin
    hi_data_o = wide_i ? hi_ext : '0;
    lo_data_o = lo_q_i;
  end
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       conv_done_i,
  input  logic [9:0] conv_data_i,
  input  logic       wide_mode_i,
  input  logic       rd_hi_i,
  input  logic       rd_lo_i,
  output logic [7:0] hi_data_o,
  output logic [7:0] lo_data_o
);
  import adc_rh_pkg::*;
  localparam int unsigned HI_W = RES_W - BYTE_W;

  logic            lock, accept, load;
  logic [HI_W-1:0] hi_q;
  logic [7:0]      lo_q;

  adc_rh_lock u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_mode_i),
    .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i),
    .lock_o(lock), .accept_o(accept)
  );

  assign load = conv_done_i && accept;

  adc_rh_store #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .wide_i(wide_mode_i),
    .data_i(conv_data_i), .hi_q_o(hi_q), .lo_q_o(lo_q)
  );

  adc_rh_view #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_view (
    .wide_i(wide_mode_i), .hi_q_i(hi_q), .lo_q_i(lo_q),
    .hi_data_o(hi_data_o), .lo_data_o(lo_data_o)
  );

  // R1
  always_comb begin
    if (rst_ni) hi_upper_zero_chk: assert (hi_data_o[7:HI_W] == '0);
  end
  // R7
  frozen_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_mode_i && lock && !rd_lo_i) |=> $stable(lo_q));
  // R5
  free_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !lock) |=> (lo_q == ($past(wide_mode_i) ?
      $past(conv_data_i[7:0]) : $past(conv_data_i[9:2]))));
endmodule

// File: tb/test_adc_result_hold.sv
module test_adc_result_hold;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done = 1'b0;
  logic [9:0] data = '0;
  logic       wide = 1'b1;
  logic       rdh = 1'b0;
  logic       rdl = 1'b0;
  logic [7:0] hi_o, lo_o;

  int checks = 0;
  int fails  = 0;

  logic [1:0] m_hi2 = '0;
  logic [7:0] m_lo  = '0;
  logic       m_lock = 1'b0;

  always #4 clk = ~clk;

  adc_result_hold i_adc_result_hold (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(done), .conv_data_i(data),
    .wide_mode_i(wide), .rd_hi_i(rdh), .rd_lo_i(rdl),
    .hi_data_o(hi_o), .lo_data_o(lo_o)
  );

  function automatic logic [7:0] exp_hi(input logic w, input logic [1:0] h);
    return w ? {6'b0, h} : 8'h00;
  endfunction

  function automatic logic [7:0] cap_lo(input logic w, input logic [9:0] d);
    return w ? d[7:0] : d[9:2];
  endfunction

  task automatic check(input string tag);
    checks++;
    if (hi_o !== exp_hi(wide, m_hi2) || lo_o !== m_lo) begin
      fails++;
      $display("FAIL %s: hi=%02h lo=%02h expected hi=%02h lo=%02h",
               tag, hi_o, lo_o, exp_hi(wide, m_hi2), m_lo);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic d_en, input logic [9:0] d, input logic w,
                      input logic h, input logic l, input string tag);
    done = d_en; data = d; wide = w; rdh = h; rdl = l;
    @(posedge clk);
    if (d_en && (!w || !m_lock || l)) begin
      m_hi2 = w ? d[9:8] : 2'b00;
      m_lo  = cap_lo(w, d);
    end
    if (!w || l)  m_lock = 1'b0;
    else if (h)   m_lock = 1'b1;
    @(negedge clk);
    done = 1'b0; rdh = 1'b0; rdl = 1'b0;
    check(tag);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4");
    step(0, 10'h000, 1, 0, 0, "R4");

    // capture in ten-bit format
    step(1, 10'h2A5, 1, 0, 0, "R5");
    check("R1"); check("R3");

    // freeze, then drop
    step(0, 10'h000, 1, 1, 0, "R6");
    step(1, 10'h15A, 1, 0, 0, "R7");
    step(0, 10'h000, 1, 0, 0, "R7");
    step(0, 10'h000, 1, 0, 1, "R6");
    step(1, 10'h0F3, 1, 0, 0, "R6");

    // completion together with clearing low read
    step(0, 10'h000, 1, 1, 0, "R10");
    step(1, 10'h3C3, 1, 0, 1, "R10");

    // high and low read together leave it clear
    step(0, 10'h000, 1, 1, 1, "R6");
    step(1, 10'h111, 1, 0, 0, "R6");

    // low read without freeze
    step(0, 10'h000, 1, 0, 1, "R9");
    step(1, 10'h2DE, 1, 0, 0, "R9");

    // eight-bit format
    step(0, 10'h000, 0, 1, 0, "R8");
    step(1, 10'h2A5, 0, 0, 0, "R8");
    check("R2"); check("R3");
    step(0, 10'h000, 0, 1, 0, "R8");
    step(1, 10'h3FF, 0, 0, 0, "R8");

    // format switch clears freeze
    step(0, 10'h000, 1, 1, 0, "R11");
    step(1, 10'h0AA, 1, 0, 0, "R11");
    step(0, 10'h000, 0, 0, 0, "R11");
    step(1, 10'h1B7, 1, 0, 0, "R11");

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, 10'($urandom), ($urandom % 8) != 0,
           ($urandom % 4) == 0, ($urandom % 5) == 0, "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule